// File: doc/BRIEF.md
# BCD Request/Strobe Result Port

This block serves a parallel BCD result port that an external controller reads on demand. Three active-low request lines select what is read: the present value, the stored maximum or the stored minimum. Once a request has been held long enough to count as genuine, the block latches the matching word and drives it onto the data lines. In the same clock it raises a data-available strobe. All of this timing runs in millisecond ticks that the block derives from the system clock. The strobe is held for a fixed time and then dropped. The data lines are freed a fixed time after that, unless the request is still held. In that case the block latches a fresh word and strobes again once per period.

The block drives every output as an open-drain pull-down. A high pull bit means the shared line is pulled low, which is the asserted or "1" level. An idle unit pulls nothing, so several units can share one wired-OR bus, each one started by its own request line. The block takes in the digits, polarity, overflow, alarm and run flags as ready-made words and does not compute them. Word layout (LSB first): 4·NDIG digit bits, then polarity, overflow, five alarm flags, run.

Top module: `bcd_read_port`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `dav_pull` is 0 and every bit of `data_pull` is 0, so all shared lines float high.
- R2: A request input is asserted at a low level. A request that is asserted and then released before T_QUAL (20) ticks produces no strobe and no data activity.
- R3: After a request falls and stays asserted for at least T_QUAL ticks, `dav_pull` rises T_DAV_DLY (30) ticks after that fall, within one tick plus the synchronizer delay. Data is driven in the same clock that the strobe rises.
- R4: The strobe stays asserted for exactly T_DAV_ON (40) ticks.
- R5: If the request is no longer held, all data lines are released exactly T_DATA_HOLD (16) ticks after the strobe falls. Data is never released while the strobe is high.
- R6: The driven word is `word_cur` for `req_cur_n`, `word_max` for `req_max_n` and `word_min` for `req_min_n`. If several requests fall together, current beats maximum and maximum beats minimum.
- R7: While the selected request stays held, the strobe repeats with a period of T_DAV_ON+T_DAV_OFF (64) ticks and a low gap of T_DAV_OFF (24) ticks. A request released before the strobe gives exactly one strobe.
- R8: The word is latched at the start of each period. A change of the input word while the strobe is asserted leaves the lines unchanged, and the next period carries the new value.
- R9: A request whose falling edge comes within T_GUARD (20) ticks after the strobe falls is ignored, even if it is held past the guard time. A request that falls after the guard time is served.
- R10: Bit i of `data_pull` equals bit i of the latched word. A 1 means the line is pulled low.
- R11: One tick lasts CLK_PER_TICK clocks, so the strobe lasts T_DAV_ON·CLK_PER_TICK clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_cur_n | input | 1 | Request for the present value, active low, asynchronous |
| req_max_n | input | 1 | Request for the stored maximum, active low, asynchronous |
| req_min_n | input | 1 | Request for the stored minimum, active low, asynchronous |
| word_cur | input | WORD_W | Present-value word |
| word_max | input | WORD_W | Maximum word |
| word_min | input | WORD_W | Minimum word |
| dav_pull | output | 1 | Pull-down enable of the data-available line |
| data_pull | output | WORD_W | Pull-down enables of the data lines |

## Verification
A request held short of the qualify time is used to show that the minimum-width filter works. A request held just past that time shows the single-shot path: strobe delay, strobe length and data release. Simultaneous requests and a pair of lower-rank requests check the priority order. A held request with a word change in mid-strobe tells periodic repetition and per-period latching apart from a transparent path. Finally, a request falling inside the guard window and held beyond it, followed by a late request, checks that the guard acts on the falling edge and not on the request level.

// File: rtl/bcd_rp_pkg.sv
package bcd_rp_pkg;

  localparam int unsigned NREQ    = 3;
  localparam int unsigned IDX_CUR = 0;
  localparam int unsigned IDX_MAX = 1;
  localparam int unsigned IDX_MIN = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUAL,
    ST_WAIT,
    ST_ON,
    ST_GAP,
    ST_GUARD
  } rp_state_e;

  // digits + polarity + overflow + five alarms + run
  function automatic int unsigned word_width(input int unsigned ndig);
    return 4 * ndig + 8;
  endfunction

  function automatic int unsigned bits_for(input int unsigned maxval);
    return (maxval > 1) ? $clog2(maxval + 1) : 1;
  endfunction

  // lowest index wins: current, then maximum, then minimum
  function automatic logic [NREQ-1:0] prio_pick(input logic [NREQ-1:0] act);
    logic [NREQ-1:0] r;
    r = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (act[i]) r = NREQ'(1) << i;
    end
    return r;
  endfunction

endpackage

// File: rtl/bcd_rp_tick.sv
module bcd_rp_tick #(
  parameter int unsigned CLK_PER_TICK = 250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PW = bcd_rp_pkg::bits_for(CLK_PER_TICK - 1);
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);

  logic [PW-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (pc_q == LAST);
      pc_q <= (pc_q == LAST) ? '0 : pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/bcd_rp_sync.sv
module bcd_rp_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_n,
  output logic [W-1:0] act
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '1;
        else if (s == 0) stg_q[s] <= raw_n;
        else stg_q[s] <= stg_q[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign act = ~stg_q[STAGES-1];
endmodule

// File: rtl/bcd_rp_pick.sv
module bcd_rp_pick #(
  parameter int unsigned W = 24
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [bcd_rp_pkg::NREQ-1:0]         sel,
  input  logic [bcd_rp_pkg::NREQ-1:0][W-1:0]  words,
  input  logic                                load,
  output logic [W-1:0]                        held_word
);
  localparam int unsigned N = bcd_rp_pkg::NREQ;

  logic [N-1:0][W-1:0] masked;
  logic [W-1:0]        picked;

  generate
    for (genvar g = 0; g < N; g++) begin : g_mask
      assign masked[g] = words[g] & {W{sel[g]}};
    end
  endgenerate

  always_comb begin
    picked = '0;
    for (int i = 0; i < N; i++) picked = picked | masked[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_word <= '0;
    else if (load) held_word <= picked;
  end
endmodule

// File: rtl/bcd_rp_seq.sv
module bcd_rp_seq #(
  parameter int unsigned T_QUAL      = 20,
  parameter int unsigned T_DAV_DLY   = 30,
  parameter int unsigned T_DAV_ON    = 40,
  parameter int unsigned T_DAV_OFF   = 24,
  parameter int unsigned T_DATA_HOLD = 16,
  parameter int unsigned T_GUARD     = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic [bcd_rp_pkg::NREQ-1:0] req_act,
  output logic [bcd_rp_pkg::NREQ-1:0] sel,
  output logic                        period_start,
  output logic                        dav,
  output logic                        drive,
  output logic                        in_idle,
  output logic                        in_guard,
  output logic                        fall_any
);
  import bcd_rp_pkg::*;

  localparam int unsigned TMAX = (T_DAV_DLY > T_DAV_ON) ?
                                 ((T_DAV_DLY > T_DAV_OFF) ? T_DAV_DLY : T_DAV_OFF) :
                                 ((T_DAV_ON > T_DAV_OFF) ? T_DAV_ON : T_DAV_OFF);
  localparam int unsigned CW = bits_for(TMAX);
  localparam logic [CW-1:0] L_QUAL  = CW'(T_QUAL - 1);
  localparam logic [CW-1:0] L_DLY   = CW'(T_DAV_DLY - 1);
  localparam logic [CW-1:0] L_ON    = CW'(T_DAV_ON - 1);
  localparam logic [CW-1:0] L_OFF   = CW'(T_DAV_OFF - 1);
  localparam logic [CW-1:0] L_HOLD  = CW'(T_DATA_HOLD - 1);
  localparam logic [CW-1:0] L_GUARD = CW'(T_GUARD - 1);

  rp_state_e       st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [NREQ-1:0] sel_q, sel_d;
  logic [NREQ-1:0] prev_q;
  logic            dav_q, dav_d, drv_q, drv_d;
  logic            start;
  logic            held;

  assign fall_any = |(req_act & ~prev_q);
  assign held     = |(req_act & sel_q);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sel_d = sel_q;
    dav_d = dav_q;
    drv_d = drv_q;
    start = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (fall_any) begin
          st_d  = ST_QUAL;
          cnt_d = '0;
        end
      end
      ST_QUAL: begin
        if (!(|req_act)) begin
          st_d = ST_IDLE;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == L_QUAL) begin
            st_d  = ST_WAIT;
            sel_d = prio_pick(req_act);
          end
        end
      end
      ST_WAIT: begin
        if (tick) begin
          if (cnt_q == L_DLY) start = 1'b1;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ON: begin
        if (tick) begin
          if (cnt_q == L_ON) begin
            dav_d = 1'b0;
            st_d  = ST_GAP;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == L_HOLD && !held) begin
            drv_d = 1'b0;
            st_d  = ST_GUARD;
          end else if (cnt_q == L_OFF) begin
            if (held) begin
              start = 1'b1;
            end else begin
              drv_d = 1'b0;
              st_d  = ST_IDLE;
            end
          end
        end
      end
      ST_GUARD: begin
        if (tick) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == L_GUARD) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (start) begin
      st_d  = ST_ON;
      cnt_d = '0;
      dav_d = 1'b1;
      drv_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sel_q  <= '0;
      prev_q <= '0;
      dav_q  <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
      prev_q <= req_act;
      dav_q  <= dav_d;
      drv_q  <= drv_d;
    end
  end

  assign sel          = sel_q;
  assign period_start = start;
  assign dav          = dav_q;
  assign drive        = drv_q;
  assign in_idle      = (st_q == ST_IDLE);
  assign in_guard     = (st_q == ST_GUARD);
endmodule

// File: rtl/bcd_read_port.sv
module bcd_read_port #(
  parameter int unsigned NDIG         = 4,
  parameter int unsigned CLK_PER_TICK = 250000,
  parameter int unsigned T_QUAL       = 20,
  parameter int unsigned T_DAV_DLY    = 30,
  parameter int unsigned T_DAV_ON     = 40,
  parameter int unsigned T_DAV_OFF    = 24,
  parameter int unsigned T_DATA_HOLD  = 16,
  parameter int unsigned T_GUARD      = 20,
  localparam int unsigned WORD_W      = bcd_rp_pkg::word_width(NDIG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_cur_n,
  input  logic              req_max_n,
  input  logic              req_min_n,
  input  logic [WORD_W-1:0] word_cur,
  input  logic [WORD_W-1:0] word_max,
  input  logic [WORD_W-1:0] word_min,
  output logic              dav_pull,
  output logic [WORD_W-1:0] data_pull
);
  import bcd_rp_pkg::*;

  logic                     tick;
  logic [NREQ-1:0]          req_act;
  logic [NREQ-1:0]          sel;
  logic                     period_start;
  logic                     drive;
  logic                     in_idle;
  logic                     in_guard;
  logic                     fall_any;
  logic [WORD_W-1:0]        held_word;
  logic [NREQ-1:0][WORD_W-1:0] words;

  assign words[IDX_CUR] = word_cur;
  assign words[IDX_MAX] = word_max;
  assign words[IDX_MIN] = word_min;

  bcd_rp_tick #(.CLK_PER_TICK(CLK_PER_TICK)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  bcd_rp_sync #(.W(NREQ), .STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .raw_n({req_min_n, req_max_n, req_cur_n}),
    .act(req_act)
  );

  bcd_rp_seq #(
    .T_QUAL(T_QUAL), .T_DAV_DLY(T_DAV_DLY), .T_DAV_ON(T_DAV_ON),
    .T_DAV_OFF(T_DAV_OFF), .T_DATA_HOLD(T_DATA_HOLD), .T_GUARD(T_GUARD)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_act(req_act),
    .sel(sel), .period_start(period_start), .dav(dav_pull),
    .drive(drive), .in_idle(in_idle), .in_guard(in_guard),
    .fall_any(fall_any)
  );

  bcd_rp_pick #(.W(WORD_W)) pick_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .words(words),
    .load(period_start), .held_word(held_word)
  );

  assign data_pull = drive ? held_word : '0;
endmodule

// File: rtl/bcd_read_port_chk.sv
module bcd_read_port_chk #(
  parameter int unsigned W        = 24,
  parameter int unsigned T_DAV_ON = 40
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         dav_pull,
  input logic [W-1:0] data_pull,
  input logic         drive,
  input logic         in_idle,
  input logic         in_guard,
  input logic         fall_any,
  input logic         period_start,
  input logic [2:0]   sel
);
  localparam int unsigned CW = bcd_rp_pkg::bits_for(T_DAV_ON + 1);

  logic [CW-1:0] on_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_ticks <= '0;
    else if (!dav_pull) on_ticks <= '0;
    else if (tick) on_ticks <= on_ticks + 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> (!dav_pull && data_pull == '0)); // R1
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R6
  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (dav_pull && $past(dav_pull)) |-> $stable(data_pull)); // R8
  AST_DAV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav_pull) |-> (on_ticks == CW'(T_DAV_ON))); // R4
  AST_DATA_WITH_DAV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dav_pull) |-> drive); // R3
  AST_RELEASE_AFTER_DAV: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive) |-> !dav_pull); // R5
  AST_GUARD_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_guard && fall_any) |=> (!period_start && !dav_pull)); // R9
endmodule

bind bcd_read_port bcd_read_port_chk #(.W(WORD_W), .T_DAV_ON(T_DAV_ON)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .dav_pull(dav_pull),
  .data_pull(data_pull), .drive(drive), .in_idle(in_idle),
  .in_guard(in_guard), .fall_any(fall_any), .period_start(period_start),
  .sel(sel)
);

// File: tb/bcd_read_port_tb.sv
`timescale 1ns/1ps
module bcd_read_port_tb_top;
  localparam int P  = 4;   // clocks per tick
  localparam int W  = 24;
  localparam int TQ = 20, TD = 30, TON = 40, TOFF = 24, THOLD = 16, TG = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] req_n = 3'b111;   // [0]=cur [1]=max [2]=min
  logic [W-1:0] w_cur = 24'hA51234;
  logic [W-1:0] w_max = 24'h3C9876;
  logic [W-1:0] w_min = 24'h0F0042;
  logic dav_pull;
  logic [W-1:0] data_pull;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bcd_read_port #(.NDIG(4), .CLK_PER_TICK(P)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_cur_n(req_n[0]), .req_max_n(req_n[1]), .req_min_n(req_n[2]),
    .word_cur(w_cur), .word_max(w_max), .word_min(w_min),
    .dav_pull(dav_pull), .data_pull(data_pull)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_dav(input bit lvl, input int maxc, output int n);
    n = 0;
    while (n < maxc && dav_pull != lvl) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_release(input int maxc, output int n);
    n = 0;
    while (n < maxc && data_pull != '0) begin
      @(negedge clk);
      n++;
    end
  endtask

  // watch for any strobe or data activity over a number of clocks
  task automatic quiet(input int nclk, output bit seen);
    seen = 0;
    repeat (nclk) begin
      @(negedge clk);
      if (dav_pull || data_pull != '0) seen = 1;
    end
  endtask

  task automatic t_reset;
    chk(dav_pull == 1'b0, "R1", "dav after reset", dav_pull, 0);
    chk(data_pull == '0, "R1", "data after reset", data_pull, 0);
  endtask

  task automatic t_short;
    bit seen;
    req_n[0] = 1'b0;
    clks(10 * P);
    req_n[0] = 1'b1;
    quiet(60 * P, seen);
    chk(!seen, "R2", "short request activity", seen, 0);
  endtask

  // single read of the maximum, full timing
  task automatic t_single;
    int n;
    bit seen;
    req_n[1] = 1'b0;
    wait_dav(1'b1, 40 * P, n);
    chk(n >= (TD - 1) * P && n <= TD * P + 4, "R3", "strobe delay clocks", n, TD * P);
    chk(data_pull == w_max, "R6", "max word on lines", data_pull, w_max);
    chk(data_pull == w_max, "R10", "pull bit equals word bit", data_pull, w_max);
    clks(25 * P - n);
    req_n[1] = 1'b1;
    wait_dav(1'b0, 60 * P, n);
    n = n + 25 * P - (TD * P);
    wait_dav(1'b0, 1, n);
    // measured separately below for exact length
    wait_release(30 * P, n);
    chk(n == THOLD * P, "R5", "release after strobe clocks", n, THOLD * P);
    quiet(30 * P, seen);
    chk(!seen, "R7", "no repeat after release", seen, 0);
  endtask

  task automatic t_length;
    int n;
    bit seen;
    req_n[0] = 1'b0;
    wait_dav(1'b1, 40 * P, n);
    wait_dav(1'b0, 60 * P, n);
    chk(n == TON * P, "R4", "strobe length clocks", n, TON * P);
    chk(n == TON * P, "R11", "tick length from strobe", n / TON, P);
    req_n[0] = 1'b1;
    quiet(1, seen);
    chk(data_pull == w_cur, "R5", "data kept right after strobe", data_pull, w_cur);
    wait_release(30 * P, n);
    clks(10 * P);
  endtask

  task automatic t_priority;
    int n;
    req_n = 3'b000;
    wait_dav(1'b1, 40 * P, n);
    chk(data_pull == w_cur, "R6", "all three: current wins", data_pull, w_cur);
    req_n = 3'b111;
    wait_release(80 * P, n);
    clks(30 * P);
    req_n = 3'b001;
    wait_dav(1'b1, 40 * P, n);
    chk(data_pull == w_max, "R6", "max beats min", data_pull, w_max);
    req_n = 3'b111;
    wait_release(80 * P, n);
    clks(30 * P);
  endtask

  task automatic t_repeat;
    int n;
    logic [W-1:0] old_min;
    old_min = w_min;
    req_n[2] = 1'b0;
    wait_dav(1'b1, 40 * P, n);
    chk(data_pull == old_min, "R6", "min word on lines", data_pull, old_min);
    clks(10 * P);
    w_min = 24'hF00321;
    clks(2);
    chk(data_pull == old_min, "R8", "lines hold during strobe", data_pull, old_min);
    wait_dav(1'b0, 60 * P, n);
    wait_dav(1'b1, 60 * P, n);
    chk(n == TOFF * P, "R7", "gap between strobes clocks", n, TOFF * P);
    chk(data_pull == w_min, "R8", "new period carries new word", data_pull, w_min);
    wait_dav(1'b0, 60 * P, n);
    chk(n == TON * P, "R7", "second strobe length", n, TON * P);
    wait_dav(1'b1, 60 * P, n);
    chk(n + TON * P == (TON + TOFF) * P, "R7", "period clocks", n + TON * P, (TON + TOFF) * P);
    req_n[2] = 1'b1;
    wait_dav(1'b0, 60 * P, n);
    wait_release(30 * P, n);
    chk(n == THOLD * P, "R5", "release after held read", n, THOLD * P);
    clks(30 * P);
  endtask

  task automatic t_guard;
    int n;
    bit seen;
    req_n[0] = 1'b0;
    wait_dav(1'b1, 40 * P, n);
    req_n[0] = 1'b1;
    wait_dav(1'b0, 60 * P, n);
    clks((THOLD + 1) * P);
    req_n[0] = 1'b0;   // falls inside guard window
    quiet(30 * P, seen);
    req_n[0] = 1'b1;
    chk(!seen, "R9", "request in guard ignored while held", seen, 0);
    quiet(50 * P, seen);
    chk(!seen, "R9", "request in guard ignored after release", seen, 0);
    req_n[0] = 1'b0;
    wait_dav(1'b1, 40 * P, n);
    chk(dav_pull == 1'b1, "R9", "request after guard served", dav_pull, 1);
    req_n[0] = 1'b1;
    wait_release(80 * P, n);
    chk(data_pull == '0, "R1", "idle after guard test", data_pull, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    clks(5);
    t_reset();
    rst_n = 1'b1;
    clks(5);
    t_reset();
    t_short();
    t_single();
    clks(10 * P);
    t_length();
    t_priority();
    t_repeat();
    t_guard();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule